// File: doc/BRIEF.md
# Three-Mode Half-Bridge PWM Input Decoder

This block sits between a motor controller's timer outputs and the dead-time stage of a three-phase gate driver. It takes three high-side inputs and three low-side inputs, one pair per phase A, B and C. It turns them into six gate-enable requests, one high and one low per phase. A 2-bit mode input chooses how the inputs are read. In six-input mode each gate has its own input. In three-input mode one input per phase sets the phase complementary. In single-PWM mode one PWM line is steered through a built-in six-step commutation table that also has overlap (dwell), align and stop states.

In single-PWM mode, four of the remaining input pins form a 4-bit state code. A decoder maps that code to a named commutation state: one of AB, AB_CB, CB, CB_CA, CA, CA_BA, BA, BA_BC, BC, BC_AC, AC, AC_AB, ALIGN or STOP. Every code that is not listed decodes to STOP. Each state gives every phase one of three roles:
- OFF: both gates off.
- CHOP: the high gate follows PWM.
- LOW: the low gate is held on.

A freewheel-select input only has an effect in this mode. It sets whether a CHOP phase's low gate carries inverted PWM (active freewheeling) or stays off (diode freewheeling). The six requests are registered once, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `hbd_input_decoder`

## Requirements
- R1: While rst_n is low, all six gate outputs are 0, whatever the inputs.
- R2: With mode 2'b00 or 2'b11, for each phase: high input alone gives gate_h=1, gate_l=0. Low input alone gives gate_h=0, gate_l=1. Both inputs 1 or both 0 gives both gates 0.
- R3: With mode 2'b01, each phase gives gate_h = in_h and gate_l = ~in_h. The low inputs have no effect.
- R4: With mode 2'b10, the state code is {in_l[0], in_h[1], in_l[1], in_h[2]} (MSB first), PWM is in_h[0], and in_l[2] has no effect. Bit 0 of each bus is phase A, bit 1 is B, bit 2 is C.
- R5: The six-step codes give these roles (A,B,C). AB=0110: CHOP,LOW,OFF. CB=0100: OFF,LOW,CHOP. CA=1100: LOW,OFF,CHOP. BA=1000: LOW,CHOP,OFF. BC=1010: OFF,CHOP,LOW. AC=0010: CHOP,OFF,LOW.
- R6: The overlap codes give these roles (A,B,C). AB_CB=0101: CHOP,LOW,CHOP. CB_CA=1101: LOW,LOW,CHOP. CA_BA=1001: LOW,CHOP,CHOP. BA_BC=1011: LOW,CHOP,LOW. BC_AC=0011: CHOP,CHOP,LOW. AC_AB=0111: CHOP,LOW,LOW.
- R7: ALIGN=1110 gives A=CHOP, B=LOW, C=LOW. STOP=0000 gives all six gates 0.
- R8: With fw_diode=0 (active freewheeling), a CHOP phase drives gate_h=PWM and gate_l=~PWM. A LOW phase drives gate_h=0, gate_l=1. An OFF phase drives both gates 0.
- R9: With fw_diode=1 (diode freewheeling), a CHOP phase drives gate_h=PWM and gate_l=0. fw_diode has no effect in modes other than 2'b10.
- R10: In mode 2'b10, the unlisted codes 0001 and 1111 drive all six gates 0.
- R11: gate_h[i] and gate_l[i] are never 1 together for any phase, in any mode, with any code.
- R12: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge (one cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Input mapping select (00/11 six, 01 three, 10 single-PWM) |
| fw_diode | input | 1 | 1 = diode freewheeling, 0 = active (single-PWM only) |
| in_h | input | 3 | High-side inputs, bit 0 = phase A |
| in_l | input | 3 | Low-side inputs, bit 0 = phase A |
| gate_h | output | 3 | Registered high-gate requests, bit 0 = phase A |
| gate_l | output | 3 | Registered low-gate requests, bit 0 = phase A |

## Verification
The bench builds the block with its only configuration: three phases and a 4-bit state code, both fixed in the package. At that size the whole input space of 4 modes × 64 input combinations × 2 freewheel settings is only 512 vectors. The bench walks all of them, so every listed and unlisted code is compared against a behavioural model. That includes both freewheel styles and the ignored pins. Targeted vectors then pin down latency and the effect of PWM polarity within a single state.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int NPH    = 3;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        MODE_SIX     = 2'b00,
        MODE_THREE   = 2'b01,
        MODE_ONE     = 2'b10,
        MODE_SIX_ALT = 2'b11
    } mode_e;

    typedef enum logic [3:0] {
        ST_STOP,
        ST_AB,
        ST_AB_CB,
        ST_CB,
        ST_CB_CA,
        ST_CA,
        ST_CA_BA,
        ST_BA,
        ST_BA_BC,
        ST_BC,
        ST_BC_AC,
        ST_AC,
        ST_AC_AB,
        ST_ALIGN
    } comm_e;

    typedef enum logic [1:0] {
        LEG_OFF,
        LEG_CHOP,
        LEG_LOW
    } leg_e;

    typedef struct packed {
        leg_e c;
        leg_e b;
        leg_e a;
    } legs_t;

endpackage

// File: rtl/hbd_step_decode.sv
module hbd_step_decode
    import hbd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output comm_e             step
);

    always_comb begin
        unique case (code)
            4'b0110: step = ST_AB;
            4'b0101: step = ST_AB_CB;
            4'b0100: step = ST_CB;
            4'b1101: step = ST_CB_CA;
            4'b1100: step = ST_CA;
            4'b1001: step = ST_CA_BA;
            4'b1000: step = ST_BA;
            4'b1011: step = ST_BA_BC;
            4'b1010: step = ST_BC;
            4'b0011: step = ST_BC_AC;
            4'b0010: step = ST_AC;
            4'b0111: step = ST_AC_AB;
            4'b1110: step = ST_ALIGN;
            default: step = ST_STOP;   // 0000 and every unlisted code
        endcase
    end

endmodule

// File: rtl/hbd_leg_table.sv
module hbd_leg_table
    import hbd_pkg::*;
(
    input  comm_e step,
    output legs_t legs
);

    always_comb begin
        unique case (step)
            ST_AB:    legs = '{c: LEG_OFF,  b: LEG_LOW,  a: LEG_CHOP};
            ST_AB_CB: legs = '{c: LEG_CHOP, b: LEG_LOW,  a: LEG_CHOP};
            ST_CB:    legs = '{c: LEG_CHOP, b: LEG_LOW,  a: LEG_OFF};
            ST_CB_CA: legs = '{c: LEG_CHOP, b: LEG_LOW,  a: LEG_LOW};
            ST_CA:    legs = '{c: LEG_CHOP, b: LEG_OFF,  a: LEG_LOW};
            ST_CA_BA: legs = '{c: LEG_CHOP, b: LEG_CHOP, a: LEG_LOW};
            ST_BA:    legs = '{c: LEG_OFF,  b: LEG_CHOP, a: LEG_LOW};
            ST_BA_BC: legs = '{c: LEG_LOW,  b: LEG_CHOP, a: LEG_LOW};
            ST_BC:    legs = '{c: LEG_LOW,  b: LEG_CHOP, a: LEG_OFF};
            ST_BC_AC: legs = '{c: LEG_LOW,  b: LEG_CHOP, a: LEG_CHOP};
            ST_AC:    legs = '{c: LEG_LOW,  b: LEG_OFF,  a: LEG_CHOP};
            ST_AC_AB: legs = '{c: LEG_LOW,  b: LEG_LOW,  a: LEG_CHOP};
            ST_ALIGN: legs = '{c: LEG_LOW,  b: LEG_LOW,  a: LEG_CHOP};
            default:  legs = '{c: LEG_OFF,  b: LEG_OFF,  a: LEG_OFF};
        endcase
    end

endmodule

// File: rtl/hbd_leg_drive.sv
module hbd_leg_drive
    import hbd_pkg::*;
(
    input  legs_t          legs,
    input  logic           pwm,
    input  logic           fw_diode,
    output logic [NPH-1:0] drv_h,
    output logic [NPH-1:0] drv_l
);

    leg_e role [NPH];

    assign role[0] = legs.a;
    assign role[1] = legs.b;
    assign role[2] = legs.c;

    for (genvar ph = 0; ph < NPH; ph++) begin : g_leg
        always_comb begin
            unique case (role[ph])
                LEG_CHOP: begin
                    drv_h[ph] = pwm;
                    drv_l[ph] = fw_diode ? 1'b0 : ~pwm;
                end
                LEG_LOW: begin
                    drv_h[ph] = 1'b0;
                    drv_l[ph] = 1'b1;
                end
                default: begin
                    drv_h[ph] = 1'b0;
                    drv_l[ph] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hbd_direct_map.sv
module hbd_direct_map
    import hbd_pkg::*;
(
    input  logic           three_in,
    input  logic [NPH-1:0] in_h,
    input  logic [NPH-1:0] in_l,
    output logic [NPH-1:0] drv_h,
    output logic [NPH-1:0] drv_l
);

    for (genvar ph = 0; ph < NPH; ph++) begin : g_ph
        always_comb begin
            if (three_in) begin
                drv_h[ph] = in_h[ph];
                drv_l[ph] = ~in_h[ph];
            end else begin
                unique case ({in_h[ph], in_l[ph]})
                    2'b10:   begin drv_h[ph] = 1'b1; drv_l[ph] = 1'b0; end
                    2'b01:   begin drv_h[ph] = 1'b0; drv_l[ph] = 1'b1; end
                    default: begin drv_h[ph] = 1'b0; drv_l[ph] = 1'b0; end
                endcase
            end
        end
    end

endmodule

// File: rtl/hbd_input_decoder.sv
module hbd_input_decoder
    import hbd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     mode,
    input  logic           fw_diode,
    input  logic [NPH-1:0] in_h,
    input  logic [NPH-1:0] in_l,
    output logic [NPH-1:0] gate_h,
    output logic [NPH-1:0] gate_l
);

    mode_e             mode_sel;
    logic [CODE_W-1:0] state_code;
    logic              pwm_in;
    comm_e             step;
    legs_t             legs;
    logic [NPH-1:0]    one_h, one_l;
    logic [NPH-1:0]    dir_h, dir_l;
    logic [NPH-1:0]    nxt_h, nxt_l;

    assign mode_sel   = mode_e'(mode);
    assign state_code = {in_l[0], in_h[1], in_l[1], in_h[2]};
    assign pwm_in     = in_h[0];

    hbd_step_decode u_step (
        .code (state_code),
        .step (step)
    );

    hbd_leg_table u_table (
        .step (step),
        .legs (legs)
    );

    hbd_leg_drive u_drive (
        .legs     (legs),
        .pwm      (pwm_in),
        .fw_diode (fw_diode),
        .drv_h    (one_h),
        .drv_l    (one_l)
    );

    hbd_direct_map u_direct (
        .three_in (mode_sel == MODE_THREE),
        .in_h     (in_h),
        .in_l     (in_l),
        .drv_h    (dir_h),
        .drv_l    (dir_l)
    );

    // Output select
    always_comb begin
        unique case (mode_sel)
            MODE_ONE: begin
                nxt_h = one_h;
                nxt_l = one_l;
            end
            default: begin
                nxt_h = dir_h;
                nxt_l = dir_l;
            end
        endcase
    end

    // Gate request register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_h <= '0;
            gate_l <= '0;
        end else begin
            gate_h <= nxt_h;
            gate_l <= nxt_l;
        end
    end

    // R11
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_h & gate_l) == '0);

    // R2
    six_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(mode) == 2'b00 || $past(mode) == 2'b11)) |->
        (gate_h == ($past(in_h) & ~$past(in_l)) &&
         gate_l == ($past(in_l) & ~$past(in_h))));

    // R3
    three_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b01) |->
        (gate_h == $past(in_h) && gate_l == ~$past(in_h)));

    // R10
    undef_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b10 &&
         ($past(state_code) == 4'b0001 || $past(state_code) == 4'b1111 ||
          $past(state_code) == 4'b0000)) |->
        (gate_h == '0 && gate_l == '0));

    // R9
    diode_fw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == 2'b10 && $past(fw_diode) &&
         !$past(in_h[0])) |-> gate_h == '0);

endmodule

// File: tb/hbd_input_decoder_bench.sv
`timescale 1ns/1ps
module hbd_input_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       fw_diode = 1'b0;
    logic [2:0] in_h = 3'b000;
    logic [2:0] in_l = 3'b000;
    logic [2:0] gate_h, gate_l;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    hbd_input_decoder u_hbd_input_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .fw_diode (fw_diode),
        .in_h     (in_h),
        .in_l     (in_l),
        .gate_h   (gate_h),
        .gate_l   (gate_l)
    );

    // roles: 0 off, 1 chop, 2 low
    function automatic void roles_of(input int code, output int ra, output int rb, output int rc);
        case (code)
            6:  begin ra = 1; rb = 2; rc = 0; end
            5:  begin ra = 1; rb = 2; rc = 1; end
            4:  begin ra = 0; rb = 2; rc = 1; end
            13: begin ra = 2; rb = 2; rc = 1; end
            12: begin ra = 2; rb = 0; rc = 1; end
            9:  begin ra = 2; rb = 1; rc = 1; end
            8:  begin ra = 2; rb = 1; rc = 0; end
            11: begin ra = 2; rb = 1; rc = 2; end
            10: begin ra = 0; rb = 1; rc = 2; end
            3:  begin ra = 1; rb = 1; rc = 2; end
            2:  begin ra = 1; rb = 0; rc = 2; end
            7:  begin ra = 1; rb = 2; rc = 2; end
            14: begin ra = 1; rb = 2; rc = 2; end
            default: begin ra = 0; rb = 0; rc = 0; end
        endcase
    endfunction

    function automatic logic [5:0] model(input logic [1:0] m, input logic [2:0] h,
                                         input logic [2:0] l, input logic fw);
        logic [2:0] eh, el;
        int r [3];
        int code;
        eh = 0; el = 0;
        if (m == 2'b01) begin
            eh = h; el = ~h;
        end else if (m == 2'b10) begin
            code = l[0] * 8 + h[1] * 4 + l[1] * 2 + h[2];
            roles_of(code, r[0], r[1], r[2]);
            for (int p = 0; p < 3; p++) begin
                if (r[p] == 1) begin
                    eh[p] = h[0];
                    el[p] = fw ? 1'b0 : !h[0];
                end else if (r[p] == 2) begin
                    el[p] = 1'b1;
                end
            end
        end else begin
            for (int p = 0; p < 3; p++) begin
                if (h[p] && !l[p]) eh[p] = 1'b1;
                if (l[p] && !h[p]) el[p] = 1'b1;
            end
        end
        return {eh, el};
    endfunction

    task automatic check(input string tag, input logic [5:0] expv);
        n_run++;
        if ({gate_h, gate_l} !== expv) begin
            n_fail++;
            $display("FAIL %s: got h=%b l=%b expected h=%b l=%b", tag,
                     gate_h, gate_l, expv[5:3], expv[2:0]);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic [2:0] h,
                         input logic [2:0] l, input logic fw);
        mode = m; in_h = h; in_l = l; fw_diode = fw;
        @(negedge clk);
    endtask

    function automatic string tag_for(input logic [1:0] m, input logic [2:0] h,
                                      input logic [2:0] l, input logic fw);
        int code;
        if (m == 2'b01) return fw ? "R9" : "R3";
        if (m != 2'b10) return fw ? "R9" : "R2";
        code = l[0] * 8 + h[1] * 4 + l[1] * 2 + h[2];
        if (l[2]) return "R4";
        if (code == 1 || code == 15) return "R10";
        if (code == 0 || code == 14) return "R7";
        if (code == 6 || code == 4 || code == 12 || code == 8 || code == 10 || code == 2)
            return fw ? "R9" : "R5";
        return fw ? "R9" : "R6";
    endfunction

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs low with active inputs
        mode = 2'b01; in_h = 3'b111; in_l = 3'b000;
        repeat (3) @(negedge clk);
        check("R1", 6'b000_000);
        mode = 2'b00; in_h = 3'b101; in_l = 3'b000;
        @(negedge clk);
        check("R1", 6'b000_000);
        rst_n = 1'b1;

        // Exhaustive sweep, compared every cycle
        for (int m = 0; m < 4; m++)
            for (int fw = 0; fw < 2; fw++)
                for (int h = 0; h < 8; h++)
                    for (int l = 0; l < 8; l++) begin
                        apply(m[1:0], h[2:0], l[2:0], fw[0]);
                        check(tag_for(m[1:0], h[2:0], l[2:0], fw[0]),
                              model(m[1:0], h[2:0], l[2:0], fw[0]));
                        n_run++;
                        if ((gate_h & gate_l) != 0) begin
                            n_fail++;
                            $display("FAIL R11: got h=%b l=%b expected no overlap", gate_h, gate_l);
                        end
                    end

        // R8: state AB, active, PWM high then low
        apply(2'b10, 3'b011, 3'b010, 1'b0);
        check("R8", {3'b001, 3'b010});
        apply(2'b10, 3'b010, 3'b010, 1'b0);
        check("R8", {3'b000, 3'b011});
        // R9: state AB, diode, PWM low
        apply(2'b10, 3'b010, 3'b010, 1'b1);
        check("R9", {3'b000, 3'b010});
        // R4: in_l[2] toggled in AB, unchanged result
        apply(2'b10, 3'b011, 3'b110, 1'b0);
        check("R4", {3'b001, 3'b010});
        // R5: CB = 0100 -> C chop, B low
        apply(2'b10, 3'b011, 3'b000, 1'b0);
        check("R5", {3'b100, 3'b010});
        // R7: ALIGN = 1110
        apply(2'b10, 3'b011, 3'b011, 1'b0);
        check("R7", {3'b001, 3'b110});

        // R12: new inputs do not show before the next rising edge
        mode = 2'b01; in_h = 3'b111; in_l = 3'b000; fw_diode = 1'b0;
        #2;
        check("R12", {3'b001, 3'b110});
        @(negedge clk);
        check("R12", {3'b111, 3'b000});

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule